// File: doc/BRIEF.md
# USB Receive Endpoint Control Logic

This block keeps the host-side control and status state of one USB receive endpoint and applies the state changes that hardware makes without software. Software writes one 8-bit control word and reads back one 8-bit status word. The packet engine reports each received packet together with short-packet, isochronous and PID-error flags. The FIFO side reports each 4-byte chunk that is read out of the receive buffer. A DMA engine reports when each packet and each whole transfer is done.

Hardware can clear the ready flag after a full-size unload. It can raise the next IN request as soon as ready clears. It drops the auto-request enable when a short packet arrives. It keeps the data toggle and lets software load the toggle only through a guarded write. It also produces a DMA request line and one interrupt line, whose source depends on the DMA mode.

Top module: `usb_rx_ep_ctl`

## Requirements
- R1: After reset, `rxrdy_o`, `reqpkt_o`, `data_tgl_o`, `dma_req_o`, `irq_o` and every bit of `reg_rdata_o` are 0.
- R2: A `pkt_rx_i` strobe sets `rxrdy_o` and clears `reqpkt_o` on the next clock edge.
- R3: When the auto-clear enable (write bit 0) is set, `rxrdy_o` clears on the edge that counts the unloaded chunk reaching `MAX_PKT` bytes. Each `fifo_chunk_rd_i` counts as 4 bytes, and a count past `MAX_PKT` is a full unload. A shorter unload leaves `rxrdy_o` set. The count restarts whenever a packet arrives or `rxrdy_o` clears.
- R4: A register write with bit 6 set clears `rxrdy_o`. A write with bit 7 set sets `reqpkt_o`.
- R5: When the auto-request enable (write bit 1) is set, `reqpkt_o` becomes 1 on the same edge where `rxrdy_o` goes from 1 to 0. This still holds when the software clear and the automatic clear fall in the same cycle.
- R6: A packet strobe with `pkt_short_i` set clears the stored auto-request enable (read bit 1).
- R7: The toggle takes write bit 5 only in a write whose bit 4 is 1. In any other write, bit 5 is ignored. The toggle-write enable is never stored. Read bit 4 is `reqpkt_o`.
- R8: The toggle (`data_tgl_o`, read bit 5) inverts on every received packet except an isochronous packet that has a PID error.
- R9: The PID-error status (read bit 7) is loaded from `pkt_pid_err_i` only on isochronous packets, so a clean isochronous packet clears it. Non-isochronous packets leave it unchanged.
- R10: `dma_req_o` is 1 exactly while the DMA enable (write bit 2) and `rxrdy_o` are both 1.
- R11: With DMA enabled, `irq_o` pulses for one cycle after each `dma_pkt_done_i` when the DMA mode (write bit 3) is 0. It pulses only after `dma_xfer_done_i` when the mode is 1.
- R12: With DMA disabled, `irq_o` pulses for one cycle after each received packet, and DMA events raise no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| arst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Control word write strobe |
| reg_wdata_i | input | 8 | Control word: 0 auto-clear, 1 auto-request, 2 DMA enable, 3 DMA mode, 4 toggle-write enable, 5 toggle value, 6 ready clear, 7 request set |
| reg_rdata_o | output | 8 | Status word: 0..3 as written, 4 request, 5 toggle, 6 ready, 7 PID error |
| fifo_chunk_rd_i | input | 1 | One 4-byte chunk read from the receive FIFO |
| pkt_rx_i | input | 1 | Packet received strobe |
| pkt_short_i | input | 1 | Received packet is short |
| pkt_iso_i | input | 1 | Received packet belongs to an isochronous transaction |
| pkt_pid_err_i | input | 1 | Received packet had a PID error |
| dma_pkt_done_i | input | 1 | DMA moved one packet |
| dma_xfer_done_i | input | 1 | DMA finished the whole transfer |
| rxrdy_o | output | 1 | Receive data ready |
| reqpkt_o | output | 1 | IN request pending |
| data_tgl_o | output | 1 | Current receive data toggle |
| dma_req_o | output | 1 | DMA service request |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The unload counter is driven with a full four-chunk unload, with a two-chunk short unload followed by a software clear, and with a three-chunk unload after that clear. These patterns separate a correct threshold from one that is off by one chunk, and a counter that restarts from one that carries over. Auto-request is tried with the automatic clear alone, with the automatic and software clears in the same cycle, and after a short packet has dropped the enable. Toggle writes are tried with the enable bit clear and set. Packets arrive as bulk with and without the error flag and as isochronous with and without it, which separates the PID-flag and toggle rules. DMA packet-done and transfer-done events are applied in both modes and with DMA disabled.

// File: rtl/usb_rxep_pkg.sv
package usb_rxep_pkg;

  localparam int unsigned CTL_W = 8;

  // write-side field positions
  localparam int unsigned WB_ACLR   = 0;
  localparam int unsigned WB_AREQ   = 1;
  localparam int unsigned WB_DMAEN  = 2;
  localparam int unsigned WB_DMAMD  = 3;
  localparam int unsigned WB_TGLWE  = 4;
  localparam int unsigned WB_TGLV   = 5;
  localparam int unsigned WB_RDYCLR = 6;
  localparam int unsigned WB_REQSET = 7;

  // read-side field positions
  localparam int unsigned RB_REQ    = 4;
  localparam int unsigned RB_TGL    = 5;
  localparam int unsigned RB_RDY    = 6;
  localparam int unsigned RB_PIDERR = 7;

  typedef struct packed {
    logic dma_mode;
    logic dma_en;
    logic auto_req;
    logic auto_clr;
  } ep_ctl_t;

endpackage

// File: rtl/rxep_rst_sync.sv
module rxep_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sr_q <= '0;
    else          sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sr_q[STAGES-1];

endmodule

// File: rtl/rxep_ready_trk.sv
module rxep_ready_trk #(
  parameter int unsigned MAX_PKT = 64,
  parameter int unsigned CHUNK_B = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pkt_rx_i,
  input  logic chunk_rd_i,
  input  logic sw_clr_i,
  input  logic req_set_i,
  input  logic auto_clr_i,
  input  logic auto_req_i,
  output logic rxrdy_o,
  output logic reqpkt_o
);

  localparam int unsigned CHUNKS = (MAX_PKT + CHUNK_B - 1) / CHUNK_B;
  localparam int unsigned CNT_W  = $clog2(CHUNKS + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             rdy_q, rdy_d, rdy_en;
  logic             req_q, req_d, req_en;
  logic             last_chunk, auto_hit, clr_any;

  // chunk that completes (or overruns) a full-size unload
  assign last_chunk = chunk_rd_i && (cnt_q >= CNT_W'(CHUNKS - 1));
  assign auto_hit   = auto_clr_i && last_chunk;
  assign clr_any    = rdy_q && !pkt_rx_i && (sw_clr_i || auto_hit);

  always_comb begin
    rdy_d  = rdy_q;
    rdy_en = 1'b0;
    if (pkt_rx_i) begin
      rdy_d  = 1'b1;
      rdy_en = 1'b1;
    end else if (clr_any) begin
      rdy_d  = 1'b0;
      rdy_en = 1'b1;
    end
  end

  always_comb begin
    req_d  = req_q;
    req_en = 1'b0;
    if (pkt_rx_i) begin
      req_d  = 1'b0;
      req_en = 1'b1;
    end else if ((clr_any && auto_req_i) || req_set_i) begin
      req_d  = 1'b1;
      req_en = 1'b1;
    end
  end

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (pkt_rx_i || clr_any) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (chunk_rd_i && rdy_q && (cnt_q != CNT_W'(CHUNKS))) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q <= 1'b0;
      req_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (rdy_en) rdy_q <= rdy_d;
      if (req_en) req_q <= req_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign rxrdy_o  = rdy_q;
  assign reqpkt_o = req_q;

  // R2: arrival sets ready and retires the request
  a_r2_arrival: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_rx_i |=> (rdy_q && !req_q));

  // R3: without auto-clear or a software clear, ready holds
  a_r3_hold_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_q && !pkt_rx_i && !sw_clr_i && !auto_clr_i) |=> rdy_q);

  // R5: a falling ready with auto-request leaves a request pending
  a_r5_req_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_q && !pkt_rx_i && sw_clr_i && auto_req_i) |=> (!rdy_q && req_q));

endmodule

// File: rtl/rxep_toggle_trk.sv
module rxep_toggle_trk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pkt_rx_i,
  input  logic pkt_iso_i,
  input  logic pkt_pid_err_i,
  input  logic tgl_wr_i,
  input  logic tgl_val_i,
  output logic tgl_o,
  output logic pid_err_o
);

  logic tgl_q, tgl_d, tgl_en;
  logic pid_q, pid_en;
  logic pkt_good;

  assign pkt_good = pkt_rx_i && !(pkt_iso_i && pkt_pid_err_i);

  always_comb begin
    tgl_d  = tgl_q;
    tgl_en = 1'b0;
    if (tgl_wr_i) begin
      tgl_d  = tgl_val_i;
      tgl_en = 1'b1;
    end else if (pkt_good) begin
      tgl_d  = !tgl_q;
      tgl_en = 1'b1;
    end
  end

  assign pid_en = pkt_rx_i && pkt_iso_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgl_q <= 1'b0;
      pid_q <= 1'b0;
    end else begin
      if (tgl_en) tgl_q <= tgl_d;
      if (pid_en) pid_q <= pkt_pid_err_i;
    end
  end

  assign tgl_o     = tgl_q;
  assign pid_err_o = pid_q;

  // R7: no guarded write and no good packet keeps the toggle
  a_r7_tgl_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tgl_wr_i && !pkt_good) |=> $stable(tgl_q));

  // R8: a good packet inverts the toggle
  a_r8_tgl_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_good && !tgl_wr_i) |=> (tgl_q != $past(tgl_q)));

  // R9: non-isochronous packets leave the PID status alone
  a_r9_pid_iso_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_rx_i && !pkt_iso_i) |=> $stable(pid_q));

endmodule

// File: rtl/rxep_irq_gen.sv
module rxep_irq_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dma_en_i,
  input  logic dma_mode_i,
  input  logic rxrdy_i,
  input  logic pkt_rx_i,
  input  logic dma_pkt_i,
  input  logic dma_xfer_i,
  output logic dma_req_o,
  output logic irq_o
);

  logic irq_q, irq_d;

  always_comb begin
    if (!dma_en_i)       irq_d = pkt_rx_i;
    else if (dma_mode_i) irq_d = dma_xfer_i;
    else                 irq_d = dma_pkt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  assign dma_req_o = dma_en_i && rxrdy_i;
  assign irq_o     = irq_q;

  // R11: whole-transfer mode stays silent on per-packet events
  a_r11_mode1_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_en_i && dma_mode_i && !dma_xfer_i) |=> !irq_q);

  // R11: per-packet mode signals every packet moved
  a_r11_mode0_pkt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_en_i && !dma_mode_i && dma_pkt_i) |=> irq_q);

  // R12: without DMA only arrivals interrupt
  a_r12_rx_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dma_en_i && !pkt_rx_i) |=> !irq_q);

endmodule

// File: rtl/usb_rx_ep_ctl.sv
module usb_rx_ep_ctl #(
  parameter int unsigned MAX_PKT   = 64,
  parameter int unsigned CHUNK_B   = 4,
  parameter int unsigned RST_SYNC  = 2
) (
  input  logic       clk_i,
  input  logic       arst_ni,
  input  logic       reg_wr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       fifo_chunk_rd_i,
  input  logic       pkt_rx_i,
  input  logic       pkt_short_i,
  input  logic       pkt_iso_i,
  input  logic       pkt_pid_err_i,
  input  logic       dma_pkt_done_i,
  input  logic       dma_xfer_done_i,
  output logic       rxrdy_o,
  output logic       reqpkt_o,
  output logic       data_tgl_o,
  output logic       dma_req_o,
  output logic       irq_o
);

  import usb_rxep_pkg::*;

  logic    rst_n;
  ep_ctl_t ctl_q, ctl_d;
  logic    ctl_en;
  logic    rdy, req, tgl, pid_err;
  logic    short_pkt;

  rxep_rst_sync #(.STAGES(RST_SYNC)) u_rst (
    .clk_i   (clk_i),
    .arst_ni (arst_ni),
    .rst_no  (rst_n)
  );

  assign short_pkt = pkt_rx_i && pkt_short_i;

  always_comb begin
    ctl_d  = ctl_q;
    ctl_en = reg_wr_i || short_pkt;
    if (reg_wr_i) begin
      ctl_d.auto_clr = reg_wdata_i[WB_ACLR];
      ctl_d.auto_req = reg_wdata_i[WB_AREQ];
      ctl_d.dma_en   = reg_wdata_i[WB_DMAEN];
      ctl_d.dma_mode = reg_wdata_i[WB_DMAMD];
    end
    if (short_pkt) ctl_d.auto_req = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  rxep_ready_trk #(.MAX_PKT(MAX_PKT), .CHUNK_B(CHUNK_B)) u_rdy (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .pkt_rx_i   (pkt_rx_i),
    .chunk_rd_i (fifo_chunk_rd_i),
    .sw_clr_i   (reg_wr_i && reg_wdata_i[WB_RDYCLR]),
    .req_set_i  (reg_wr_i && reg_wdata_i[WB_REQSET]),
    .auto_clr_i (ctl_q.auto_clr),
    .auto_req_i (ctl_q.auto_req),
    .rxrdy_o    (rdy),
    .reqpkt_o   (req)
  );

  rxep_toggle_trk u_tgl (
    .clk_i         (clk_i),
    .rst_ni        (rst_n),
    .pkt_rx_i      (pkt_rx_i),
    .pkt_iso_i     (pkt_iso_i),
    .pkt_pid_err_i (pkt_pid_err_i),
    .tgl_wr_i      (reg_wr_i && reg_wdata_i[WB_TGLWE]),
    .tgl_val_i     (reg_wdata_i[WB_TGLV]),
    .tgl_o         (tgl),
    .pid_err_o     (pid_err)
  );

  rxep_irq_gen u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .dma_en_i   (ctl_q.dma_en),
    .dma_mode_i (ctl_q.dma_mode),
    .rxrdy_i    (rdy),
    .pkt_rx_i   (pkt_rx_i),
    .dma_pkt_i  (dma_pkt_done_i),
    .dma_xfer_i (dma_xfer_done_i),
    .dma_req_o  (dma_req_o),
    .irq_o      (irq_o)
  );

  always_comb begin
    reg_rdata_o            = '0;
    reg_rdata_o[WB_ACLR]   = ctl_q.auto_clr;
    reg_rdata_o[WB_AREQ]   = ctl_q.auto_req;
    reg_rdata_o[WB_DMAEN]  = ctl_q.dma_en;
    reg_rdata_o[WB_DMAMD]  = ctl_q.dma_mode;
    reg_rdata_o[RB_REQ]    = req;
    reg_rdata_o[RB_TGL]    = tgl;
    reg_rdata_o[RB_RDY]    = rdy;
    reg_rdata_o[RB_PIDERR] = pid_err;
  end

  assign rxrdy_o    = rdy;
  assign reqpkt_o   = req;
  assign data_tgl_o = tgl;

  // R6: a short packet drops the auto-request enable
  a_r6_short_drop: assert property (@(posedge clk_i) disable iff (!rst_n)
    short_pkt |=> !ctl_q.auto_req);

  // R10: a falling DMA enable withdraws the request
  a_r10_req_gate: assert property (@(posedge clk_i) disable iff (!rst_n)
    (reg_wr_i && !reg_wdata_i[WB_DMAEN]) |=> !dma_req_o);

endmodule

// File: tb/usb_rx_ep_ctl_tb_top.sv
`timescale 1ns/1ps
module usb_rx_ep_ctl_tb_top;

  localparam int unsigned MAXP = 16;

  // stimulus bits: chunk, pkt, short, iso, piderr, dma pkt, dma xfer
  localparam logic [6:0] S_NONE = 7'b0000000;
  localparam logic [6:0] S_CHK  = 7'b1000000;
  localparam logic [6:0] S_PRX  = 7'b0100000;
  localparam logic [6:0] S_PSH  = 7'b0010000;
  localparam logic [6:0] S_ISO  = 7'b0001000;
  localparam logic [6:0] S_PERR = 7'b0000100;
  localparam logic [6:0] S_DPK  = 7'b0000010;
  localparam logic [6:0] S_DXF  = 7'b0000001;

  typedef struct {
    logic       rdy;
    logic       req;
    logic       tgl;
    logic       dreq;
    logic       irq;
    logic [7:0] rd;
    string      tag;
  } exp_t;

  logic       clk, arst_n;
  logic       reg_wr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       chunk_rd, pkt_rx, pkt_short, pkt_iso, pkt_perr, dma_pkt, dma_xfer;
  logic       rxrdy, reqpkt, tgl, dma_req, irq;

  int   errs   = 0;
  int   checks = 0;
  exp_t sb_q[$];
  bit   done   = 0;

  usb_rx_ep_ctl #(.MAX_PKT(MAXP)) dut_i (
    .clk_i           (clk),
    .arst_ni         (arst_n),
    .reg_wr_i        (reg_wr),
    .reg_wdata_i     (reg_wdata),
    .reg_rdata_o     (reg_rdata),
    .fifo_chunk_rd_i (chunk_rd),
    .pkt_rx_i        (pkt_rx),
    .pkt_short_i     (pkt_short),
    .pkt_iso_i       (pkt_iso),
    .pkt_pid_err_i   (pkt_perr),
    .dma_pkt_done_i  (dma_pkt),
    .dma_xfer_done_i (dma_xfer),
    .rxrdy_o         (rxrdy),
    .reqpkt_o        (reqpkt),
    .data_tgl_o      (tgl),
    .dma_req_o       (dma_req),
    .irq_o           (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // driver: apply one cycle of stimulus and queue the expected result
  task automatic step(input logic wr, input logic [7:0] wd, input logic [6:0] s,
                      input logic e_rdy, input logic e_req, input logic e_tgl,
                      input logic e_dreq, input logic e_irq, input logic [7:0] e_rd,
                      input string tag);
    exp_t e;
    @(negedge clk);
    reg_wr    = wr;
    reg_wdata = wd;
    {chunk_rd, pkt_rx, pkt_short, pkt_iso, pkt_perr, dma_pkt, dma_xfer} = s;
    e.rdy = e_rdy; e.req = e_req; e.tgl = e_tgl; e.dreq = e_dreq;
    e.irq = e_irq; e.rd = e_rd; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: compare shortly after the edge that consumed the stimulus
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (rxrdy !== e.rdy || reqpkt !== e.req || tgl !== e.tgl ||
            dma_req !== e.dreq || irq !== e.irq || reg_rdata !== e.rd) begin
          errs++;
          $display("FAIL %s: got rdy=%b req=%b tgl=%b dreq=%b irq=%b rd=%h exp rdy=%b req=%b tgl=%b dreq=%b irq=%b rd=%h",
                   e.tag, rxrdy, reqpkt, tgl, dma_req, irq, reg_rdata,
                   e.rdy, e.req, e.tgl, e.dreq, e.irq, e.rd);
        end
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    arst_n = 1'b0;
    reg_wr = 1'b0; reg_wdata = '0;
    {chunk_rd, pkt_rx, pkt_short, pkt_iso, pkt_perr, dma_pkt, dma_xfer} = S_NONE;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    checks++;
    if ({rxrdy, reqpkt, tgl, dma_req, irq} !== 5'b0 || reg_rdata !== 8'h00) begin
      errs++;
      $display("FAIL R1: got outs=%b rd=%h exp outs=00000 rd=00",
               {rxrdy, reqpkt, tgl, dma_req, irq}, reg_rdata);
    end

    step(0, 8'h00, S_NONE, 0,0,0,0,0, 8'h00, "R1 idle");
    step(1, 8'h03, S_NONE, 0,0,0,0,0, 8'h03, "R3 enable auto");
    step(0, 8'h00, S_PRX,  1,0,1,0,1, 8'h63, "R2 R8 R12 arrival");
    for (int i = 0; i < 3; i++)
      step(0, 8'h00, S_CHK, 1,0,1,0,0, 8'h63, "R3 partial unload");
    step(0, 8'h00, S_CHK,  0,1,1,0,0, 8'h33, "R3 R5 full unload");
    step(0, 8'h00, S_PRX | S_PSH, 1,0,0,0,1, 8'h41, "R6 short packet");
    for (int i = 0; i < 2; i++)
      step(0, 8'h00, S_CHK, 1,0,0,0,0, 8'h41, "R3 short unload");
    step(1, 8'h41, S_NONE, 0,0,0,0,0, 8'h01, "R4 sw clear");
    step(1, 8'h03, S_NONE, 0,0,0,0,0, 8'h03, "R6 re-enable");
    step(0, 8'h00, S_PRX,  1,0,1,0,1, 8'h63, "R2 arrival");
    for (int i = 0; i < 3; i++)
      step(0, 8'h00, S_CHK, 1,0,1,0,0, 8'h63, "R3 count restart");
    step(1, 8'h43, S_CHK,  0,1,1,0,0, 8'h33, "R5 dual clear");
    step(1, 8'h03, S_NONE, 0,1,1,0,0, 8'h33, "R7 unguarded toggle");
    step(1, 8'h13, S_NONE, 0,1,0,0,0, 8'h13, "R7 guarded toggle 0");
    step(1, 8'h33, S_NONE, 0,1,1,0,0, 8'h33, "R7 guarded toggle 1");
    step(1, 8'h00, S_NONE, 0,1,1,0,0, 8'h30, "R7 ctl off");
    step(0, 8'h00, S_PRX | S_ISO | S_PERR, 1,0,1,0,1, 8'hE0, "R8 R9 iso error");
    step(1, 8'h40, S_NONE, 0,0,1,0,0, 8'hA0, "R4 clear");
    step(0, 8'h00, S_PRX | S_PERR, 1,0,0,0,1, 8'hC0, "R9 bulk keeps pid");
    step(1, 8'h40, S_NONE, 0,0,0,0,0, 8'h80, "R4 clear");
    step(0, 8'h00, S_PRX | S_ISO, 1,0,1,0,1, 8'h60, "R9 clean iso");
    step(1, 8'h40, S_NONE, 0,0,1,0,0, 8'h20, "R4 clear");
    step(1, 8'h04, S_NONE, 0,0,1,0,0, 8'h24, "R10 dma on idle");
    step(0, 8'h00, S_PRX,  1,0,0,1,0, 8'h44, "R10 R12 dma arrival");
    step(0, 8'h00, S_DPK,  1,0,0,1,1, 8'h44, "R11 mode0 pkt");
    step(0, 8'h00, S_DXF,  1,0,0,1,0, 8'h44, "R11 mode0 xfer");
    step(1, 8'h4C, S_NONE, 0,0,0,0,0, 8'h0C, "R10 mode1 clear");
    step(0, 8'h00, S_DPK,  0,0,0,0,0, 8'h0C, "R11 mode1 pkt");
    step(0, 8'h00, S_DXF,  0,0,0,0,1, 8'h0C, "R11 mode1 xfer");
    step(1, 8'h08, S_NONE, 0,0,0,0,0, 8'h08, "R12 dma off");
    step(0, 8'h00, S_DXF,  0,0,0,0,0, 8'h08, "R12 no dma irq");
    step(0, 8'h00, S_PRX,  1,0,1,0,1, 8'h68, "R10 R12 arrival");
    step(1, 8'h80, S_NONE, 1,1,1,0,0, 8'h70, "R4 req set");
    step(0, 8'h00, S_NONE, 1,1,1,0,0, 8'h70, "R4 hold");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule